// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dial Generator

This block takes numeric digits and turns each one into a train of timed line breaks on a single line-break output. It can also produce a timed flash (register recall) break on the same output when asked. All timing is counted in ticks of an external one-millisecond strobe. Digits 1 to 9 produce that many breaks and digit 0 produces ten. The pulse rate is ten per second. A strap chooses one of two break/make splits. After each digit comes a long pause before the next digit may start.

Digits arrive over a valid/ready stream. A source raises `dig_valid` with a code and must hold both unchanged until it sees `dig_ready` high at a clock edge. That edge is the transfer. The block applies back-pressure by keeping `dig_ready` low for these periods:
- while a digit is pulsing;
- during the pause that follows a digit;
- during a flash;
- while a flash request is waiting or arriving.

Codes above 9 are still taken from the stream, but they are dropped and produce no output. The flash request, flash-extend level and ratio strap are plain control pins. The line-break, busy and mute outputs are plain status pins.

Top module: `loop_pulse_dialer`

## Requirements
- R1: After reset, `line_brk`, `busy` and `mute` are 0 and `dig_ready` is 1.
- R2: An accepted code 1 to 9 produces exactly that many breaks. Code 0 produces ten breaks. A break is `line_brk` = 1, and the idle (make) level is 0.
- R3: The strap is sampled when a digit is accepted. With `ratio_sel` = 0, each break lasts 67 ticks and each make lasts 33 ticks. With `ratio_sel` = 1, each break lasts 60 ticks and each make lasts 40 ticks.
- R4: Changing `ratio_sel` after a digit has been accepted has no effect on that digit's timing.
- R5: After the last make of a digit there is a pause of 840 ticks. `dig_ready` stays 0 from acceptance until that pause ends.
- R6: An accepted code from 10 to 15 is discarded. No break occurs, `mute` stays 0 and the block stays idle.
- R7: A flash request while idle drives `line_brk` to 1 for at least 100 ticks. If `flash_ext` is 1 once that minimum has passed, the break continues until `flash_ext` returns to 0.
- R8: A flash request made while a digit is pulsing or pausing is held. It is performed right after that pause ends, before any new digit. A flash request during a flash is ignored.
- R9: `mute` is 1 from the first break of a digit until the end of its pause, and 0 otherwise. `busy` is 1 whenever a digit, a pause, a flash or a held flash request is in progress.
- R10: `dig_ready` is 1 only when the block is idle, no flash is held and `flash_req` is 0. A code is taken only on an edge where `dig_valid` and `dig_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| dig_valid | input | 1 | Digit code offered |
| dig_code | input | 4 | Digit code; 0 to 9 dialled, 10 to 15 discarded |
| dig_ready | output | 1 | Block takes the offered code at this edge |
| flash_req | input | 1 | Request a flash break (one-cycle pulse or level) |
| flash_ext | input | 1 | Holds the flash break beyond its minimum while 1 |
| ratio_sel | input | 1 | Break/make split: 0 gives 67/33, 1 gives 60/40 |
| line_brk | output | 1 | Line-break output, 1 means line open |
| busy | output | 1 | Pulsing, pausing, flashing or flash held |
| mute | output | 1 | Mute request during a digit and its pause |

## Verification
A wrong tick count or a wrong pulse counter shows up directly on `line_brk`. Its edges move or an edge goes missing within the same break or make period. A bad pause counter or a lost held flash shows up on `dig_ready`, `busy` or `mute`. The symptom appears at the end of the pause at the latest, which is up to 840 ticks after the last make. A reference model steps through every cycle alongside the design, so the first diverging cycle is reported. Break widths are also measured in ticks at the port and compared with the strap setting.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BRK   = 3'd1,
    ST_MAKE  = 3'd2,
    ST_PAUSE = 3'd3,
    ST_FLASH = 3'd4
  } dial_st_t;

  // number of breaks for a code; 0 marks a code that is not dialled
  function automatic logic [3:0] breaks_for(input logic [3:0] code);
    if (code == 4'd0)       return 4'd10;
    else if (code <= 4'd9)  return code;
    else                    return 4'd0;
  endfunction
endpackage

// File: rtl/dpg_tick_counter.sv
module dpg_tick_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] q
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= '0;
    else if (tick && q != TOP)  q <= q + 1'b1;
  end
endmodule

// File: rtl/dpg_ratio_latch.sv
module dpg_ratio_latch #(
  parameter int CW       = 10,
  parameter int BRK_2TO1 = 67,
  parameter int MK_2TO1  = 33,
  parameter int BRK_3TO2 = 60,
  parameter int MK_3TO2  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          sel_in,
  output logic [CW-1:0] brk_len,
  output logic [CW-1:0] mk_len
);
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= 1'b0;
    else if (load) sel_q <= sel_in;
  end

  always_comb begin
    if (sel_q) begin
      brk_len = CW'(BRK_3TO2);
      mk_len  = CW'(MK_3TO2);
    end else begin
      brk_len = CW'(BRK_2TO1);
      mk_len  = CW'(MK_2TO1);
    end
  end

  // R4: the strap copy only moves when a digit is accepted
  a_r4_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));
endmodule

// File: rtl/dpg_sequencer.sv
module dpg_sequencer
  import dpg_pkg::*;
#(
  parameter int CW        = 10,
  parameter int PAUSE_MS  = 840,
  parameter int FLASH_MIN = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          dig_valid,
  input  logic [3:0]    dig_code,
  output logic          dig_ready,
  input  logic          flash_req,
  input  logic          flash_ext,
  input  logic [CW-1:0] brk_len,
  input  logic [CW-1:0] mk_len,
  input  logic [CW-1:0] cnt_q,
  output logic          cnt_clr,
  output logic          ratio_load,
  output logic          line_brk,
  output logic          busy,
  output logic          mute
);
  localparam logic [CW-1:0] PAUSE_END = CW'(PAUSE_MS - 1);
  localparam logic [CW-1:0] FL_MIN    = CW'(FLASH_MIN);

  dial_st_t   st, st_n;
  logic [3:0] left, left_n;
  logic       pend, pend_n;
  logic [3:0] dcount;
  logic       in_digit;

  assign dcount   = breaks_for(dig_code);
  assign in_digit = (st == ST_BRK) || (st == ST_MAKE) || (st == ST_PAUSE);

  assign dig_ready = (st == ST_IDLE) && !pend && !flash_req;
  assign line_brk  = (st == ST_BRK) || (st == ST_FLASH);
  assign mute      = in_digit;
  assign busy      = (st != ST_IDLE) || pend;

  always_comb begin
    st_n       = st;
    left_n     = left;
    pend_n     = pend;
    ratio_load = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (flash_req || pend) begin
          st_n   = ST_FLASH;
          pend_n = 1'b0;
        end else if (dig_valid && dig_ready && dcount != 4'd0) begin
          st_n       = ST_BRK;
          left_n     = dcount;
          ratio_load = 1'b1;
        end
      end
      ST_BRK: begin
        if (ms_tick && cnt_q == brk_len - 1'b1) st_n = ST_MAKE;
      end
      ST_MAKE: begin
        if (ms_tick && cnt_q == mk_len - 1'b1) begin
          if (left == 4'd1) st_n = ST_PAUSE;
          else begin
            left_n = left - 4'd1;
            st_n   = ST_BRK;
          end
        end
      end
      ST_PAUSE: begin
        if (ms_tick && cnt_q == PAUSE_END) st_n = ST_IDLE;
      end
      ST_FLASH: begin
        if (cnt_q >= FL_MIN && !flash_ext) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (flash_req && in_digit) pend_n = 1'b1;
  end

  assign cnt_clr = (st == ST_IDLE) || (st_n != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      left <= 4'd0;
      pend <= 1'b0;
    end else begin
      st   <= st_n;
      left <= left_n;
      pend <= pend_n;
    end
  end

  // R2: a digit in progress always has between one and ten breaks to go
  a_r2_left_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BRK) |-> (left != 4'd0 && left <= 4'd10));
  // R6: a discarded code leaves the line and mute untouched
  a_r6_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && dig_ready && dig_code > 4'd9) |=> (!line_brk && !mute));
  // R7: the flash break cannot end before its minimum
  a_r7_flash_min: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLASH && cnt_q < FL_MIN) |=> (st == ST_FLASH));
  // R8: a held flash is served as soon as the pause ends
  a_r8_held_flash: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && st == ST_IDLE) |=> (st == ST_FLASH));
endmodule

// File: rtl/loop_pulse_dialer.sv
module loop_pulse_dialer #(
  parameter int BRK_2TO1  = 67,
  parameter int MK_2TO1   = 33,
  parameter int BRK_3TO2  = 60,
  parameter int MK_3TO2   = 40,
  parameter int PAUSE_MS  = 840,
  parameter int FLASH_MIN = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       dig_valid,
  input  logic [3:0] dig_code,
  output logic       dig_ready,
  input  logic       flash_req,
  input  logic       flash_ext,
  input  logic       ratio_sel,
  output logic       line_brk,
  output logic       busy,
  output logic       mute
);
  localparam int LONG1   = (PAUSE_MS > FLASH_MIN) ? PAUSE_MS : FLASH_MIN;
  localparam int LONG2   = (BRK_2TO1 > BRK_3TO2) ? BRK_2TO1 : BRK_3TO2;
  localparam int LONGEST = (LONG1 > LONG2) ? LONG1 : LONG2;
  localparam int CW      = $clog2(LONGEST + 2);

  logic [CW-1:0] cnt_q, brk_len, mk_len;
  logic          cnt_clr, ratio_load;

  dpg_tick_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(ms_tick), .q(cnt_q)
  );

  dpg_ratio_latch #(
    .CW(CW), .BRK_2TO1(BRK_2TO1), .MK_2TO1(MK_2TO1),
    .BRK_3TO2(BRK_3TO2), .MK_3TO2(MK_3TO2)
  ) u_ratio (
    .clk(clk), .rst_n(rst_n), .load(ratio_load), .sel_in(ratio_sel),
    .brk_len(brk_len), .mk_len(mk_len)
  );

  dpg_sequencer #(.CW(CW), .PAUSE_MS(PAUSE_MS), .FLASH_MIN(FLASH_MIN)) u_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .dig_valid(dig_valid), .dig_code(dig_code), .dig_ready(dig_ready),
    .flash_req(flash_req), .flash_ext(flash_ext),
    .brk_len(brk_len), .mk_len(mk_len), .cnt_q(cnt_q), .cnt_clr(cnt_clr),
    .ratio_load(ratio_load), .line_brk(line_brk), .busy(busy), .mute(mute)
  );

  // R10: taking a code never coincides with an active line or mute
  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dig_ready |-> (!line_brk && !mute));
  // R9: mute is a subset of busy
  a_r9_mute_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mute |-> busy);
endmodule

// File: tb/sim_loop_pulse_dialer.sv
`timescale 1ns/1ps
module sim_loop_pulse_dialer;
  logic clk = 0, rst_n = 0, ms_tick = 0, dig_valid = 0;
  logic [3:0] dig_code = 0;
  logic flash_req = 0, flash_ext = 0, ratio_sel = 0;
  logic dig_ready, line_brk, busy, mute;

  int checks = 0, errors = 0, cycles = 0;
  int tdiv = 0;
  bit run = 0;

  always #2.5 clk = ~clk;

  loop_pulse_dialer u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .dig_valid(dig_valid),
    .dig_code(dig_code), .dig_ready(dig_ready), .flash_req(flash_req),
    .flash_ext(flash_ext), .ratio_sel(ratio_sel), .line_brk(line_brk),
    .busy(busy), .mute(mute)
  );

  // millisecond strobe: one cycle in four
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv + 1) % 4;
    ms_tick = run && (tdiv == 0);
  end

  // behavioural reference: 0 idle, 1 break, 2 make, 3 pause, 4 flash
  int ms = 0, mcnt = 0, mleft = 0, mratio = 0;
  bit mpend = 0;
  always @(posedge clk) begin
    int bl, ml, old;
    bit rdy;
    cycles++;
    if (!rst_n) begin
      ms = 0; mcnt = 0; mleft = 0; mpend = 0; mratio = 0;
    end else begin
      bl = mratio ? 60 : 67;
      ml = mratio ? 40 : 33;
      old = ms;
      rdy = (ms == 0) && !mpend && !flash_req;
      case (ms)
        0: if (flash_req || mpend) begin ms = 4; mpend = 0; mcnt = 0; end
           else if (dig_valid && rdy && dig_code <= 9) begin
             ms = 1; mcnt = 0; mratio = ratio_sel;
             mleft = (dig_code == 0) ? 10 : dig_code;
           end
        1: if (ms_tick) begin
             if (mcnt == bl - 1) begin ms = 2; mcnt = 0; end else mcnt++;
           end
        2: if (ms_tick) begin
             if (mcnt == ml - 1) begin
               mcnt = 0;
               if (mleft == 1) ms = 3; else begin mleft--; ms = 1; end
             end else mcnt++;
           end
        3: if (ms_tick) begin
             if (mcnt == 839) begin ms = 0; mcnt = 0; end else mcnt++;
           end
        4: if (mcnt >= 100 && !flash_ext) begin ms = 0; mcnt = 0; end
           else if (ms_tick) mcnt++;
        default: ms = 0;
      endcase
      if (flash_req && old >= 1 && old <= 3) mpend = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 20) $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) if (rst_n && run) begin
    chk(line_brk == (ms == 1 || ms == 4), "R2 R3 R7 line_brk", line_brk, (ms == 1 || ms == 4));
    chk(mute == (ms >= 1 && ms <= 3), "R9 mute", mute, (ms >= 1 && ms <= 3));
    chk(busy == (ms != 0 || mpend), "R9 busy", busy, (ms != 0 || mpend));
    chk(dig_ready == (ms == 0 && !mpend && !flash_req), "R5 R10 dig_ready",
        dig_ready, (ms == 0 && !mpend && !flash_req));
  end

  // break widths in ticks, measured at the port
  int wq[$];
  int wcur = 0;
  bit wprev = 0;
  always @(posedge clk) if (rst_n) begin
    if (line_brk) begin
      if (ms_tick) wcur++;
    end else if (wprev) begin
      wq.push_back(wcur);
      wcur = 0;
    end
    wprev = line_brk;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    finish_run();
  end

  task automatic send(input int code);
    @(posedge clk); #1;
    dig_valid = 1; dig_code = 4'(code);
    do @(negedge clk); while (!dig_ready);
    @(posedge clk); #1;
    dig_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 30000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_widths(input int n, input int w, input string tag);
    chk(wq.size() == n, {tag, " break count"}, wq.size(), n);
    foreach (wq[i]) chk(wq[i] == w, {tag, " break width"}, wq[i], w);
    wq.delete();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    // R1: reset state
    chk(line_brk == 0, "R1 line_brk", line_brk, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(mute == 0, "R1 mute", mute, 0);
    chk(dig_ready == 1, "R1 dig_ready", dig_ready, 1);
    @(posedge clk); #1; rst_n = 1; run = 1;
    repeat (5) @(posedge clk);

    // R2 R3: digit 3 on the 2:1 strap
    ratio_sel = 0;
    send(3);
    wait_idle();
    expect_widths(3, 67, "R2 R3 digit3");

    // R2 R3 R4: digit 0 on the 3:2 strap, strap flipped mid-digit
    ratio_sel = 1;
    send(0);
    repeat (600) @(posedge clk);
    #1 ratio_sel = 0;
    wait_idle();
    expect_widths(10, 60, "R2 R4 digit0");

    // R6: codes above 9 are consumed and dropped
    send(12);
    send(15);
    repeat (40) @(negedge clk);
    chk(mute == 0 && busy == 0, "R6 stays idle", busy, 0);
    expect_widths(0, 0, "R6 discard");

    // R7: plain flash
    @(posedge clk); #1 flash_req = 1;
    @(posedge clk); #1 flash_req = 0;
    wait_idle();
    expect_widths(1, 100, "R7 flash");

    // R7: extended flash, extend held to about 160 ticks
    @(posedge clk); #1 flash_req = 1; flash_ext = 1;
    @(posedge clk); #1 flash_req = 0;
    repeat (640) @(posedge clk);
    #1 flash_ext = 0;
    wait_idle();
    chk(wq.size() == 1, "R7 ext count", wq.size(), 1);
    if (wq.size() == 1) chk(wq[0] >= 155, "R7 ext width", wq[0], 160);
    wq.delete();

    // R8: flash requested during a digit waits for its pause
    ratio_sel = 0;
    send(2);
    repeat (100) @(posedge clk);
    #1 flash_req = 1;
    @(posedge clk); #1 flash_req = 0;
    @(negedge clk);
    chk(busy == 1, "R8 held busy", busy, 1);
    wait_idle();
    chk(wq.size() == 3, "R8 count", wq.size(), 3);
    if (wq.size() == 3) begin
      chk(wq[0] == 67 && wq[1] == 67, "R8 digit widths", wq[1], 67);
      chk(wq[2] == 100, "R8 flash width", wq[2], 100);
    end
    wq.delete();

    // R5 R10: a second digit waits out the pause under back-pressure
    send(1);
    send(5);
    wait_idle();
    expect_widths(6, 67, "R5 R10 back-to-back");

    finish_run();
  end
endmodule